// File: doc/BRIEF.md
# Memory Port Width Up-Converter

This block sits between a requester that speaks in narrow words (32 bits by default) and a memory port that moves wide words (128 bits by default, so four lanes). Narrow commands that follow each other, go in the same direction and fall inside the same wide word are collected into a group. The group then leaves as one wide command. Write data and byte enables from each narrow write are steered into their lane of an accumulated wide word. For a wide read, one narrow response is produced for every narrow read in the group, in the order the reads were made.

A group closes when the next narrow command falls in a different wide word, when it goes in the other direction, or when a narrow command carries the last flag. Groups may be incomplete or have holes: any subset of lanes may be touched, in any order. Lanes that no write touched keep their byte enables clear. Narrow write data and wide read data each pass through a small FIFO. Lane indices of pending reads wait in a queue until the wide response comes back.

Top module: `mem_upconv`

## Requirements
- R1: While reset is held and in the cycle after it, w_cmd_valid, w_wdata_valid and n_rdata_valid are 0.
- R2: Consecutive narrow commands of the same direction whose address bits above the lane field (narrow address >> log2(RATIO)) are equal produce exactly one wide command. Its w_cmd_addr is that shifted address, and w_cmd_we=1 means write.
- R3: A narrow command whose wide-word address differs from the open group closes that group and issues its wide command.
- R4: A narrow command whose direction differs from the open group closes that group and issues its wide command.
- R5: A narrow command accepted with n_cmd_last=1 closes its group, and that group's wide command is issued without any further narrow command. The cycle after such an accept, n_cmd_ready is 0.
- R6: For a narrow write to lane k (the low log2(RATIO) address bits), data byte j is placed at wide byte k*NB+j and enable bit j at wide enable bit k*NB+j, where NB is the number of narrow bytes. Each group starts with all enables 0. Wide data bytes whose enable stays 0 are 0.
- R7: A wide write command is not issued while its group is still open, that is before a closing narrow command or a last flag.
- R8: Each narrow read returns lane k of the wide read response for its group, and the responses come back in request order.
- R9: Gapped groups work: a group touching only lanes 0, 2 and 3 gives one wide write with lane 1 enables 0.
- R10: While w_cmd_valid=1 and w_cmd_ready=0, w_cmd_valid stays 1 and w_cmd_addr and w_cmd_we do not change in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| n_cmd_valid | input | 1 | Narrow command valid |
| n_cmd_ready | output | 1 | Narrow command accepted |
| n_cmd_we | input | 1 | 1 = write, 0 = read |
| n_cmd_addr | input | AW | Narrow word address |
| n_cmd_last | input | 1 | Close the group after this command |
| n_wdata_valid | input | 1 | Narrow write data valid |
| n_wdata_ready | output | 1 | Narrow write data accepted |
| n_wdata | input | NW | Narrow write data |
| n_wbe | input | NW/8 | Narrow byte enables |
| n_rdata_valid | output | 1 | Narrow read data valid |
| n_rdata_ready | input | 1 | Narrow read data taken |
| n_rdata | output | NW | Narrow read data |
| w_cmd_valid | output | 1 | Wide command valid |
| w_cmd_ready | input | 1 | Wide command accepted |
| w_cmd_we | output | 1 | Wide command direction, 1 = write |
| w_cmd_addr | output | AW-log2(RATIO) | Wide word address |
| w_wdata_valid | output | 1 | Wide write data valid |
| w_wdata_ready | input | 1 | Wide write data taken |
| w_wdata | output | NW*RATIO | Wide write data |
| w_wbe | output | NW*RATIO/8 | Wide byte enables |
| w_rdata_valid | input | 1 | Wide read data valid |
| w_rdata_ready | output | 1 | Wide read data accepted |
| w_rdata | input | NW*RATIO | Wide read data |

## Verification
The checks assume the memory side answers wide reads in the order it accepted them, one response per wide read command. They also assume every narrow write command has its data pushed no later than the command itself. The bench's memory model queues accepted read addresses and replies strictly in that order. It pushes each write's data before offering the command, so the FIFO and hold properties see only legal traffic. The bench also lets the wide command port stall in a fixed pattern, and in one test holds it off for several cycles, to exercise the hold rule.

// File: rtl/upc_pkg.sv
package upc_pkg;
  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } dir_e;
endpackage

// File: rtl/upc_fifo.sv
module upc_fifo #(
  parameter int W          = 32,
  parameter int DEPTH_LOG2 = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int DEPTH = 1 << DEPTH_LOG2;

  logic [W-1:0]          mem [DEPTH];
  logic [DEPTH_LOG2-1:0] wr_ptr, rd_ptr;
  logic [DEPTH_LOG2:0]   cnt;

  assign full  = (cnt == DEPTH[DEPTH_LOG2:0]);
  assign empty = (cnt == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R8: no data is lost or invented in the storage paths
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/upc_pack.sv
module upc_pack
  import upc_pkg::*;
#(
  parameter int NW    = 32,
  parameter int RATIO = 4,
  parameter int AW    = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     n_cmd_valid,
  output logic                     n_cmd_ready,
  input  logic                     n_cmd_we,
  input  logic [AW-1:0]            n_cmd_addr,
  input  logic                     n_cmd_last,
  input  logic                     wd_empty,
  input  logic [NW-1:0]            wd_data,
  input  logic [NW/8-1:0]          wd_be,
  output logic                     wd_pop,
  input  logic                     ww_full,
  output logic                     ww_push,
  output logic [NW*RATIO-1:0]      ww_data,
  output logic [NW*RATIO/8-1:0]    ww_be,
  input  logic                     lq_full,
  output logic                     lq_push,
  output logic [$clog2(RATIO)-1:0] lq_lane,
  output logic                     lq_end,
  output logic                     w_cmd_valid,
  input  logic                     w_cmd_ready,
  output logic                     w_cmd_we,
  output logic [AW-$clog2(RATIO)-1:0] w_cmd_addr
);
  localparam int LW  = $clog2(RATIO);
  localparam int WW  = NW * RATIO;
  localparam int WB  = WW / 8;
  localparam int WAW = AW - LW;

  logic           grp_open, close_req;
  dir_e           grp_dir;
  logic [WAW-1:0] grp_wa;
  logic [WW-1:0]  acc_data;
  logic [WB-1:0]  acc_be;
  logic [LW-1:0]  pend_lane;

  logic [WAW-1:0] in_wa;
  logic [LW-1:0]  in_lane;
  dir_e           in_dir;
  logic           hit, slot_free, close_ok, new_ok;
  logic           do_close, do_accept, do_start;
  logic [WW-1:0]  sh_data, byte_mask;
  logic [WB-1:0]  sh_be;

  assign in_wa   = n_cmd_addr[AW-1:LW];
  assign in_lane = n_cmd_addr[LW-1:0];
  assign in_dir  = dir_e'(n_cmd_we);

  assign hit       = grp_open && (in_wa == grp_wa) && (in_dir == grp_dir);
  assign slot_free = !w_cmd_valid || w_cmd_ready;
  assign close_ok  = slot_free && ((grp_dir == DIR_WR) ? !ww_full : !lq_full);
  assign new_ok    = n_cmd_we ? !wd_empty : 1'b1;

  // lane steering of the write data and enables
  assign sh_data = n_cmd_we ? (WW'(wd_data) << (NW * in_lane)) : '0;
  assign sh_be   = n_cmd_we ? (WB'(wd_be) << ((NW / 8) * in_lane)) : '0;

  generate
    for (genvar b = 0; b < WB; b++) begin : g_mask
      assign byte_mask[b*8 +: 8] = {8{sh_be[b]}};
    end
  endgenerate

  always_comb begin
    do_close  = 1'b0;
    do_accept = 1'b0;
    do_start  = 1'b0;
    if (close_req) begin
      do_close = close_ok;
    end else if (n_cmd_valid) begin
      if (!grp_open) begin
        do_accept = new_ok;
        do_start  = new_ok;
      end else if (hit) begin
        do_accept = new_ok && (n_cmd_we || !lq_full);
      end else begin
        do_close  = close_ok && new_ok;
        do_accept = do_close;
        do_start  = do_close;
      end
    end
  end

  assign n_cmd_ready = do_accept;
  assign wd_pop      = do_accept && n_cmd_we;
  assign ww_push     = do_close && (grp_dir == DIR_WR);
  assign ww_data     = acc_data;
  assign ww_be       = acc_be;
  assign lq_push     = (do_close && (grp_dir == DIR_RD)) || (do_accept && hit && !n_cmd_we);
  assign lq_lane     = pend_lane;
  assign lq_end      = do_close;

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_open    <= 1'b0;
      close_req   <= 1'b0;
      grp_dir     <= DIR_RD;
      grp_wa      <= '0;
      acc_data    <= '0;
      acc_be      <= '0;
      pend_lane   <= '0;
      w_cmd_valid <= 1'b0;
      w_cmd_we    <= 1'b0;
      w_cmd_addr  <= '0;
    end else begin
      if (do_close) begin
        w_cmd_valid <= 1'b1;
        w_cmd_we    <= (grp_dir == DIR_WR);
        w_cmd_addr  <= grp_wa;
        grp_open    <= 1'b0;
        close_req   <= 1'b0;
      end else if (w_cmd_ready) begin
        w_cmd_valid <= 1'b0;
      end
      if (do_start) begin
        grp_open <= 1'b1;
        grp_dir  <= in_dir;
        grp_wa   <= in_wa;
        acc_data <= sh_data & byte_mask;
        acc_be   <= sh_be;
      end else if (do_accept) begin
        acc_data <= (acc_data & ~byte_mask) | (sh_data & byte_mask);
        acc_be   <= acc_be | sh_be;
      end
      if (do_accept) begin
        pend_lane <= in_lane;
        if (n_cmd_last) close_req <= 1'b1;
      end
    end
  end

  // R10: an offered wide command is held until taken
  a_r10_cmd_hold: assert property (@(posedge clk) disable iff (rst)
    (w_cmd_valid && !w_cmd_ready) |=> (w_cmd_valid && $stable(w_cmd_addr) && $stable(w_cmd_we)));
  // R5: the cycle after a last command is spent closing its group
  a_r5_last_closes: assert property (@(posedge clk) disable iff (rst)
    (n_cmd_valid && n_cmd_ready && n_cmd_last) |=> !n_cmd_ready);
endmodule

// File: rtl/upc_unpack.sv
module upc_unpack #(
  parameter int NW    = 32,
  parameter int RATIO = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     lq_empty,
  input  logic [$clog2(RATIO)-1:0] lq_lane,
  input  logic                     lq_end,
  output logic                     lq_pop,
  input  logic                     rf_empty,
  input  logic [NW*RATIO-1:0]      rf_data,
  output logic                     rf_pop,
  output logic                     n_rdata_valid,
  input  logic                     n_rdata_ready,
  output logic [NW-1:0]            n_rdata
);
  logic load;

  assign load   = (!n_rdata_valid || n_rdata_ready) && !lq_empty && !rf_empty;
  assign lq_pop = load;
  assign rf_pop = load && lq_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      n_rdata_valid <= 1'b0;
      n_rdata       <= '0;
    end else if (load) begin
      n_rdata_valid <= 1'b1;
      n_rdata       <= rf_data[NW*lq_lane +: NW];
    end else if (n_rdata_ready) begin
      n_rdata_valid <= 1'b0;
    end
  end

  // R8: a narrow response is held until taken
  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    (n_rdata_valid && !n_rdata_ready) |=> (n_rdata_valid && $stable(n_rdata)));
endmodule

// File: rtl/mem_upconv.sv
module mem_upconv #(
  parameter int NW         = 32,
  parameter int RATIO      = 4,
  parameter int AW         = 16,
  parameter int FIFO_LOG2  = 3,
  localparam int LW        = $clog2(RATIO),
  localparam int WW        = NW * RATIO,
  localparam int NB        = NW / 8,
  localparam int WB        = WW / 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            n_cmd_valid,
  output logic            n_cmd_ready,
  input  logic            n_cmd_we,
  input  logic [AW-1:0]   n_cmd_addr,
  input  logic            n_cmd_last,
  input  logic            n_wdata_valid,
  output logic            n_wdata_ready,
  input  logic [NW-1:0]   n_wdata,
  input  logic [NB-1:0]   n_wbe,
  output logic            n_rdata_valid,
  input  logic            n_rdata_ready,
  output logic [NW-1:0]   n_rdata,
  output logic            w_cmd_valid,
  input  logic            w_cmd_ready,
  output logic            w_cmd_we,
  output logic [AW-LW-1:0] w_cmd_addr,
  output logic            w_wdata_valid,
  input  logic            w_wdata_ready,
  output logic [WW-1:0]   w_wdata,
  output logic [WB-1:0]   w_wbe,
  input  logic            w_rdata_valid,
  output logic            w_rdata_ready,
  input  logic [WW-1:0]   w_rdata
);
  logic          wdf_full, wdf_empty, wdf_pop;
  logic [NW-1:0] wdf_data;
  logic [NB-1:0] wdf_be;

  logic          wwf_full, wwf_empty, wwf_push;
  logic [WW-1:0] wwf_din_d;
  logic [WB-1:0] wwf_din_be;

  logic          lq_full, lq_empty, lq_push, lq_pop, lq_end_in, lq_end_out;
  logic [LW-1:0] lq_lane_in, lq_lane_out;

  logic          rf_full, rf_empty, rf_pop;
  logic [WW-1:0] rf_data;

  assign n_wdata_ready = !wdf_full;
  assign w_wdata_valid = !wwf_empty;
  assign w_rdata_ready = !rf_full;

  upc_fifo #(.W(NW + NB), .DEPTH_LOG2(FIFO_LOG2)) u_wdf (
    .clk(clk), .rst(rst),
    .push(n_wdata_valid && !wdf_full), .din({n_wbe, n_wdata}),
    .pop(wdf_pop), .dout({wdf_be, wdf_data}),
    .full(wdf_full), .empty(wdf_empty)
  );

  upc_fifo #(.W(WW + WB), .DEPTH_LOG2(FIFO_LOG2)) u_wwf (
    .clk(clk), .rst(rst),
    .push(wwf_push), .din({wwf_din_be, wwf_din_d}),
    .pop(w_wdata_valid && w_wdata_ready), .dout({w_wbe, w_wdata}),
    .full(wwf_full), .empty(wwf_empty)
  );

  upc_fifo #(.W(LW + 1), .DEPTH_LOG2(FIFO_LOG2)) u_lq (
    .clk(clk), .rst(rst),
    .push(lq_push), .din({lq_end_in, lq_lane_in}),
    .pop(lq_pop), .dout({lq_end_out, lq_lane_out}),
    .full(lq_full), .empty(lq_empty)
  );

  upc_fifo #(.W(WW), .DEPTH_LOG2(FIFO_LOG2)) u_rf (
    .clk(clk), .rst(rst),
    .push(w_rdata_valid && !rf_full), .din(w_rdata),
    .pop(rf_pop), .dout(rf_data),
    .full(rf_full), .empty(rf_empty)
  );

  upc_pack #(.NW(NW), .RATIO(RATIO), .AW(AW)) u_pack (
    .clk(clk), .rst(rst),
    .n_cmd_valid(n_cmd_valid), .n_cmd_ready(n_cmd_ready),
    .n_cmd_we(n_cmd_we), .n_cmd_addr(n_cmd_addr), .n_cmd_last(n_cmd_last),
    .wd_empty(wdf_empty), .wd_data(wdf_data), .wd_be(wdf_be), .wd_pop(wdf_pop),
    .ww_full(wwf_full), .ww_push(wwf_push), .ww_data(wwf_din_d), .ww_be(wwf_din_be),
    .lq_full(lq_full), .lq_push(lq_push), .lq_lane(lq_lane_in), .lq_end(lq_end_in),
    .w_cmd_valid(w_cmd_valid), .w_cmd_ready(w_cmd_ready),
    .w_cmd_we(w_cmd_we), .w_cmd_addr(w_cmd_addr)
  );

  upc_unpack #(.NW(NW), .RATIO(RATIO)) u_unpack (
    .clk(clk), .rst(rst),
    .lq_empty(lq_empty), .lq_lane(lq_lane_out), .lq_end(lq_end_out), .lq_pop(lq_pop),
    .rf_empty(rf_empty), .rf_data(rf_data), .rf_pop(rf_pop),
    .n_rdata_valid(n_rdata_valid), .n_rdata_ready(n_rdata_ready), .n_rdata(n_rdata)
  );
endmodule

// File: tb/mem_upconv_test.sv
module mem_upconv_test;
  typedef struct packed {
    logic        we;
    logic        last;
    logic [15:0] addr;
    logic [3:0]  be;
    logic [31:0] data;
  } op_t;

  // table walk: narrow operations
  localparam int NOPS = 9;
  localparam op_t OPS [NOPS] = '{
    '{1'b1, 1'b0, 16'h0010, 4'hF, 32'hA0A0_0000},
    '{1'b1, 1'b0, 16'h0012, 4'h3, 32'h1234_5602},
    '{1'b1, 1'b0, 16'h0013, 4'hF, 32'hA0A0_0003},
    '{1'b1, 1'b0, 16'h0014, 4'hF, 32'hB0B0_B0B0},
    '{1'b0, 1'b0, 16'h0015, 4'h0, 32'h0},
    '{1'b0, 1'b0, 16'h0017, 4'h0, 32'h0},
    '{1'b0, 1'b1, 16'h0016, 4'h0, 32'h0},
    '{1'b0, 1'b1, 16'h0020, 4'h0, 32'h0},
    '{1'b1, 1'b1, 16'h0021, 4'h4, 32'hC1C2_C3C4}
  };
  localparam int NEXP = 7;
  localparam logic        EXP_WE   [NEXP] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [13:0] EXP_ADDR [NEXP] = '{14'h4, 14'h5, 14'h5, 14'h8, 14'h8, 14'hC, 14'h10};
  localparam logic [127:0] EXP_WD [4] = '{
    {32'hA0A0_0003, 32'h0000_5602, 32'h0, 32'hA0A0_0000},
    {96'h0, 32'hB0B0_B0B0},
    {64'h0, 32'h00C2_0000, 32'h0},
    {64'h0, 32'h0000_00E1, 32'hE0E0_E0E0}
  };
  localparam logic [15:0] EXP_BE [4] = '{16'hF30F, 16'h000F, 16'h0040, 16'h001F};
  localparam logic [31:0] EXP_RD [5] = '{32'hD005_0001, 32'hD005_0003, 32'hD005_0002,
                                         32'hD008_0000, 32'hD010_0000};

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic         n_cmd_valid = 0, n_cmd_we = 0, n_cmd_last = 0;
  logic [15:0]  n_cmd_addr = 0;
  logic         n_cmd_ready, n_wdata_ready, n_rdata_valid;
  logic         n_wdata_valid = 0, n_rdata_ready = 1;
  logic [31:0]  n_wdata = 0, n_rdata;
  logic [3:0]   n_wbe = 0;
  logic         w_cmd_valid, w_cmd_we, w_wdata_valid, w_rdata_ready;
  logic         w_cmd_ready = 0, w_wdata_ready = 1, w_rdata_valid = 0;
  logic [13:0]  w_cmd_addr;
  logic [127:0] w_wdata, w_rdata = 0;
  logic [15:0]  w_wbe;

  mem_upconv uut (
    .clk(clk), .rst(rst),
    .n_cmd_valid(n_cmd_valid), .n_cmd_ready(n_cmd_ready), .n_cmd_we(n_cmd_we),
    .n_cmd_addr(n_cmd_addr), .n_cmd_last(n_cmd_last),
    .n_wdata_valid(n_wdata_valid), .n_wdata_ready(n_wdata_ready),
    .n_wdata(n_wdata), .n_wbe(n_wbe),
    .n_rdata_valid(n_rdata_valid), .n_rdata_ready(n_rdata_ready), .n_rdata(n_rdata),
    .w_cmd_valid(w_cmd_valid), .w_cmd_ready(w_cmd_ready), .w_cmd_we(w_cmd_we),
    .w_cmd_addr(w_cmd_addr),
    .w_wdata_valid(w_wdata_valid), .w_wdata_ready(w_wdata_ready),
    .w_wdata(w_wdata), .w_wbe(w_wbe),
    .w_rdata_valid(w_rdata_valid), .w_rdata_ready(w_rdata_ready), .w_rdata(w_rdata)
  );

  int checks = 0, errors = 0;
  bit done = 0, hold_ready = 0;

  logic         got_we   [16];
  logic [13:0]  got_addr [16];
  logic [127:0] got_wd   [16];
  logic [15:0]  got_be   [16];
  logic [31:0]  got_rd   [16];
  logic [13:0]  rq_addr  [16];
  int ncmd = 0, nwd = 0, nrd = 0, rq_head = 0, rq_tail = 0, cyc = 0;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mem_word(input logic [13:0] wa);
    logic [127:0] w;
    for (int k = 0; k < 4; k++) w[k*32 +: 32] = {8'hD0, wa[7:0], 8'h00, 8'(k)};
    return w;
  endfunction

  // memory-side model and narrow read collector
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      w_cmd_ready   = !hold_ready && (cyc % 3 != 2);
      n_rdata_ready = (cyc % 4 != 3);
      w_rdata_valid = (rq_head != rq_tail);
      w_rdata       = mem_word(rq_addr[rq_head % 16]);
      #1;
      if (!rst) begin
        if (w_cmd_valid && w_cmd_ready) begin
          got_we[ncmd % 16] = w_cmd_we;
          got_addr[ncmd % 16] = w_cmd_addr;
          ncmd++;
          if (!w_cmd_we) begin
            rq_addr[rq_tail % 16] = w_cmd_addr;
            rq_tail++;
          end
        end
        if (w_wdata_valid && w_wdata_ready) begin
          got_wd[nwd % 16] = w_wdata;
          got_be[nwd % 16] = w_wbe;
          nwd++;
        end
        if (w_rdata_valid && w_rdata_ready) rq_head++;
        if (n_rdata_valid && n_rdata_ready) begin
          got_rd[nrd % 16] = n_rdata;
          nrd++;
        end
      end
    end
  end

  task automatic send_op(input op_t op);
    if (op.we) begin
      @(negedge clk);
      n_wdata_valid = 1; n_wdata = op.data; n_wbe = op.be;
      #1;
      while (!n_wdata_ready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      n_wdata_valid = 0;
    end
    @(negedge clk);
    n_cmd_valid = 1; n_cmd_we = op.we; n_cmd_addr = op.addr; n_cmd_last = op.last;
    #1;
    while (!n_cmd_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    n_cmd_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [13:0] a0;
    logic        v0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 w_cmd_valid", w_cmd_valid, 0);
    check("R1 w_wdata_valid", w_wdata_valid, 0);
    check("R1 n_rdata_valid", n_rdata_valid, 0);
    @(negedge clk); rst = 0;
    @(negedge clk); #2;
    check("R1 w_cmd_valid after", w_cmd_valid, 0);

    for (int i = 0; i < NOPS; i++) send_op(OPS[i]);
    repeat (30) @(negedge clk);

    // R7: open write group issues nothing
    send_op('{1'b1, 1'b0, 16'h0030, 4'hF, 32'hE0E0_E0E0});
    repeat (10) @(negedge clk);
    check("R7 no wide write while open", 128'(ncmd), 128'd5);
    send_op('{1'b1, 1'b1, 16'h0031, 4'h1, 32'hE1E1_E1E1});
    repeat (10) @(negedge clk);

    // R10: held wide command stays stable
    hold_ready = 1;
    send_op('{1'b0, 1'b1, 16'h0040, 4'h0, 32'h0});
    repeat (3) @(negedge clk);
    #2; v0 = w_cmd_valid; a0 = w_cmd_addr;
    check("R10 valid held", v0, 1);
    repeat (2) @(negedge clk);
    #2;
    check("R10 still valid", w_cmd_valid, 1);
    check("R10 addr stable", w_cmd_addr, a0);
    hold_ready = 0;
    repeat (30) @(negedge clk);

    // R2 R3 R4 R5: wide command sequence
    check("R2 wide command count", 128'(ncmd), 128'(NEXP));
    for (int i = 0; i < NEXP; i++) begin
      check($sformatf("R3 R4 cmd %0d dir", i), got_we[i], EXP_WE[i]);
      check($sformatf("R2 R5 cmd %0d addr", i), got_addr[i], EXP_ADDR[i]);
    end
    // R6 R9: lane packing, masking and gaps
    check("R6 wide data count", 128'(nwd), 128'd4);
    for (int i = 0; i < 4; i++) begin
      check($sformatf("R6 R9 wdata %0d", i), got_wd[i], EXP_WD[i]);
      check($sformatf("R6 R9 wbe %0d", i), got_be[i], EXP_BE[i]);
    end
    // R8: read split in request order
    check("R8 read count", 128'(nrd), 128'd5);
    for (int i = 0; i < 5; i++)
      check($sformatf("R8 rdata %0d", i), got_rd[i], EXP_RD[i]);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule